// File: doc/BRIEF.md
# Memory Interconnect Test-Mode Controller

This block sits behind the pins of a slave memory device such as an asynchronous SRAM. It watches the already-synchronized control strobes and the 19-bit address bus and decides when the device enters or leaves a board-level interconnect test mode. No extra pins are used. Test mode is entered only through strobe combinations that normal traffic does not produce. One entry path is a write-like pattern that must persist for a timed window of about 150 µs. The other is all four main strobes going active on the same sample.

While in test mode, the data bus is driven from the test logic instead of the memory array. The response is selected by address-line commands and is one of four sources: a continuity pattern derived from the address inputs, the 32-bit device identifier read a byte at a time, the identifier read a bit at a time, or three falling-edge counters on the OE#, WE# and CE1# pins. Test mode is left on an ordinary write access, or on a fixed exit pattern on the upper address lines qualified by a rising edge on the lowest address bit.

Top module: `memtest_entry_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until entry, `test_mode` is 0, `data_out` is 0 and `data_oe` is 0.
- R2: Timed entry: the write-like condition (oe_n high, we_n low, ce1_n low, ce2 high, plus the byte qualifier) must be sampled high on HOLD_CYC+1 consecutive clock edges. HOLD_CYC = CLK_KHZ*HOLD_US/1000. `test_mode` rises after the last of those edges. A single sample without the condition restarts the count.
- R3: The byte qualifier of the timed entry is byte_n low, or both ble_n and bhe_n low. Only one of ble_n/bhe_n low with byte_n high never enters.
- R4: Simultaneous entry: if one sample shows oe_n, we_n and ce1_n high with ce2 low, and the next sample shows oe_n, we_n and ce1_n low with ce2 high, `test_mode` is 1 after that second edge. A staggered activation does not enter.
- R5: Write exit: a write pattern (oe_n high, we_n low, ce1_n low, ce2 high) clears `test_mode` on the edge that samples it. This holds only once a sample inside test mode has lacked that pattern. A write pattern held on from a timed entry does not exit.
- R6: Command exit: addr[18:1] = 18'b111111000000111111 together with addr[0] going 0 to 1 between samples clears `test_mode`. The same pattern with addr[0] held at 1 does not.
- R7: Every entry selects continuity mode. In it, data_out[i] = addr[i] XOR addr[15-i] for i = 0..7, registered one cycle after the address is sampled.
- R8: A mode command is addr[18:9] = 10'b1010010110 with an addr[0] 0-to-1 edge, given inside test mode. addr[2:1] picks the mode: 00 continuity, 01 identifier byte, 10 counters, 11 identifier bit.
- R9: In identifier-byte mode, addr[4:3] = 0,1,2,3 returns ID bits [31:24], [23:16], [15:8], [7:0].
- R10: In identifier-bit mode, addr[7:3] = k returns data_out = {7'b0, ID[k]}.
- R11: In test mode, each falling edge of oe_n, we_n or ce1_n increments its own 8-bit counter, which saturates at 255. All counters clear on every entry. In counter mode, addr[4:3] = 0,1,2 reads the OE, WE and CE1 counter, and 3 reads 0.
- R12: `data_oe` is the registered value of (test_mode AND oe_n low). `data_out` is 0 whenever test mode was off at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| byte_n | input | 1 | Byte-mode select, active low |
| ble_n | input | 1 | Lower byte enable, active low |
| bhe_n | input | 1 | Upper byte enable, active low |
| addr | input | 19 | Address bus, also carries commands and stimulus |
| test_mode | output | 1 | Test mode active |
| data_oe | output | 1 | Data bus drive enable from test logic |
| data_out | output | 8 | Test response on the data bus |

## Verification
The bench breaks the timed entry condition for one cycle just before it would expire. A design that fails to restart the count enters early. It holds the window at exactly one sample short, where an off-by-one timer enters too soon or too late. It keeps the write-like entry pattern held after a timed entry, where a write exit without the release guard would drop test mode at once. It drives only one byte enable, where a wrong qualifier enters. It holds the exit pattern with addr[0] already high to catch a level-sensitive exit. It toggles a strobe past 255 to catch wraparound, and re-enters after counting to show the counters were cleared.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam int ID_W   = 32;
  localparam int NUM_CNT = 3;

  localparam logic [9:0]  CMD_KEY  = 10'b1010010110;
  localparam logic [17:0] EXIT_PAT = 18'b111111000000111111;

  typedef enum logic [1:0] {
    MODE_CONT   = 2'b00,
    MODE_IDBYTE = 2'b01,
    MODE_CNT    = 2'b10,
    MODE_IDBIT  = 2'b11
  } tm_mode_e;
endpackage

// File: rtl/mt_entry_detect.sv
module mt_entry_detect #(
  parameter int HOLD_CYC = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_act,
  input  logic we_act,
  input  logic ce1_act,
  input  logic ce2_act,
  input  logic byte_act,
  input  logic ble_act,
  input  logic bhe_act,
  input  logic exit_cmd,
  output logic test_mode,
  output logic enter_pulse
);
  localparam int TW = $clog2(HOLD_CYC + 1);
  localparam logic [TW-1:0] HOLD_LIM = TW'(HOLD_CYC);

  logic [TW-1:0] hold_q, hold_d;
  logic tm_q, tm_d;
  logic armed_q, armed_d;
  logic prev_idle_q;

  logic cond_a, wr_pat, all_on, now_idle, enter_b, hold_done, write_exit;

  always_comb begin
    wr_pat     = ~oe_act & we_act & ce1_act & ce2_act;
    cond_a     = wr_pat & (byte_act | (ble_act & bhe_act));
    all_on     = oe_act & we_act & ce1_act & ce2_act;
    now_idle   = ~oe_act & ~we_act & ~ce1_act & ~ce2_act;
    enter_b    = all_on & prev_idle_q;
    hold_done  = cond_a && (hold_q == HOLD_LIM);
    write_exit = tm_q & armed_q & wr_pat;
  end

  always_comb begin
    hold_d      = hold_q;
    tm_d        = tm_q;
    armed_d     = armed_q;
    enter_pulse = 1'b0;
    if (tm_q) begin
      hold_d = '0;
      if (write_exit || exit_cmd) begin
        tm_d    = 1'b0;
        armed_d = 1'b0;
      end else if (!wr_pat) begin
        armed_d = 1'b1;
      end
    end else begin
      armed_d = 1'b0;
      if (!cond_a)                hold_d = '0;
      else if (hold_q != HOLD_LIM) hold_d = hold_q + 1'b1;
      if (hold_done || enter_b) begin
        tm_d        = 1'b1;
        enter_pulse = 1'b1;
        hold_d      = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      tm_q        <= 1'b0;
      armed_q     <= 1'b0;
      prev_idle_q <= 1'b0;
    end else begin
      hold_q      <= hold_d;
      tm_q        <= tm_d;
      armed_q     <= armed_d;
      prev_idle_q <= now_idle;
    end
  end

  assign test_mode = tm_q;

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= HOLD_LIM); // R2
  AST_TIMED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tm_q) && !$past(enter_b)) |-> ($past(hold_q) == HOLD_LIM)); // R2
  AST_SIMUL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tm_q && all_on && prev_idle_q) |=> tm_q); // R4
  AST_WRITE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q && armed_q && wr_pat) |=> !tm_q); // R5
  AST_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q && !armed_q && !exit_cmd) |=> tm_q); // R5
  AST_CMD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q && exit_cmd) |=> !tm_q); // R6
endmodule

// File: rtl/mt_cmd_decode.sv
module mt_cmd_decode
  import memtest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              test_mode,
  input  logic              enter,
  output logic              exit_cmd,
  output tm_mode_e          mode_q
);
  logic     a0_q;
  logic     a0_rise, cmd_hit;
  tm_mode_e mode_d;

  always_comb begin
    a0_rise  = addr[0] & ~a0_q;
    exit_cmd = a0_rise && (addr[18:1] == EXIT_PAT);
    cmd_hit  = a0_rise && (addr[18:9] == CMD_KEY);
  end

  always_comb begin
    mode_d = mode_q;
    if (enter)                       mode_d = MODE_CONT;
    else if (test_mode && cmd_hit)   mode_d = tm_mode_e'(addr[2:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0_q   <= 1'b0;
      mode_q <= MODE_CONT;
    end else begin
      a0_q   <= addr[0];
      mode_q <= mode_d;
    end
  end

  AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (mode_q == MODE_CONT)); // R7
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && cmd_hit && !enter) |=> (mode_q == tm_mode_e'($past(addr[2:1])))); // R8
endmodule

// File: rtl/mt_fall_counter.sv
module mt_fall_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_n,
  input  logic             count_en,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fall;

  always_comb begin
    fall  = prev_q & ~pin_n;
    cnt_d = cnt_q;
    if (clear)                                    cnt_d = '0;
    else if (count_en && fall && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= pin_n;
      cnt_q  <= cnt_d;
    end
  end

  assign count = cnt_q;

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clear) |=> (cnt_q == CNT_MAX)); // R11
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(count_en && fall)) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/memtest_entry_ctrl.sv
module memtest_entry_ctrl
  import memtest_pkg::*;
#(
  parameter int          CLK_KHZ = 50000,
  parameter int          HOLD_US = 150,
  parameter logic [31:0] ID_CODE = 32'hC3A5_1E69,
  parameter int          CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              byte_n,
  input  logic              ble_n,
  input  logic              bhe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              test_mode,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out
);
  localparam int HOLD_CYC = (CLK_KHZ * HOLD_US) / 1000;

  logic [1:0] rst_sync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  logic     exit_cmd, enter_pulse, tm;
  tm_mode_e mode;

  mt_entry_detect #(.HOLD_CYC(HOLD_CYC)) u_entry (
    .clk        (clk),
    .rst_n      (rst_int),
    .oe_act     (~oe_n),
    .we_act     (~we_n),
    .ce1_act    (~ce1_n),
    .ce2_act    (ce2),
    .byte_act   (~byte_n),
    .ble_act    (~ble_n),
    .bhe_act    (~bhe_n),
    .exit_cmd   (exit_cmd),
    .test_mode  (tm),
    .enter_pulse(enter_pulse)
  );

  mt_cmd_decode u_cmd (
    .clk      (clk),
    .rst_n    (rst_int),
    .addr     (addr),
    .test_mode(tm),
    .enter    (enter_pulse),
    .exit_cmd (exit_cmd),
    .mode_q   (mode)
  );

  logic [NUM_CNT-1:0] strobe_n;
  logic [CNT_W-1:0]   cnt_v [NUM_CNT];
  assign strobe_n = {ce1_n, we_n, oe_n};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    mt_fall_counter #(.CNT_W(CNT_W)) u_fc (
      .clk     (clk),
      .rst_n   (rst_int),
      .pin_n   (strobe_n[g]),
      .count_en(tm),
      .clear   (enter_pulse),
      .count   (cnt_v[g])
    );
  end

  logic [DATA_W-1:0] cont_resp;
  for (genvar i = 0; i < DATA_W; i++) begin : g_cont
    assign cont_resp[i] = addr[i] ^ addr[2*DATA_W-1-i];
  end

  logic [1:0]        sel;
  logic [DATA_W-1:0] rd_val, data_d;
  logic              oe_d;

  always_comb begin
    sel = addr[4:3];
    unique case (mode)
      MODE_CONT:   rd_val = cont_resp;
      MODE_IDBYTE: rd_val = ID_CODE[{~sel, 3'b000} +: DATA_W];
      MODE_IDBIT:  rd_val = {{(DATA_W-1){1'b0}}, ID_CODE[addr[7:3]]};
      MODE_CNT: begin
        case (sel)
          2'd0:    rd_val = DATA_W'(cnt_v[0]);
          2'd1:    rd_val = DATA_W'(cnt_v[1]);
          2'd2:    rd_val = DATA_W'(cnt_v[2]);
          default: rd_val = '0;
        endcase
      end
      default:     rd_val = '0;
    endcase
    data_d = tm ? rd_val : '0;
    oe_d   = tm & ~oe_n;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      data_out <= '0;
      data_oe  <= 1'b0;
    end else begin
      data_out <= data_d;
      data_oe  <= oe_d;
    end
  end

  assign test_mode = tm;

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_int)
    !$past(tm) |-> (data_out == '0 && !data_oe)); // R12
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_int)
    data_oe |-> ($past(oe_n) == 1'b0)); // R12
endmodule

// File: tb/tb_memtest_entry_ctrl.sv
module tb_memtest_entry_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          TB_KHZ     = 100;
  localparam int          TB_US      = 150;
  localparam int          HOLD       = (TB_KHZ * TB_US) / 1000;
  localparam logic [31:0] TB_ID      = 32'hC3A5_1E69;
  localparam logic [9:0]  KEY        = 10'b1010010110;
  localparam logic [17:0] XPAT       = 18'b111111000000111111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        oe_n, we_n, ce1_n, ce2, byte_n, ble_n, bhe_n;
  logic [18:0] addr;
  logic        test_mode, data_oe;
  logic [7:0]  data_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memtest_entry_ctrl #(.CLK_KHZ(TB_KHZ), .HOLD_US(TB_US), .ID_CODE(TB_ID), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .we_n(we_n), .ce1_n(ce1_n), .ce2(ce2),
    .byte_n(byte_n), .ble_n(ble_n), .bhe_n(bhe_n), .addr(addr),
    .test_mode(test_mode), .data_oe(data_oe), .data_out(data_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idle();
    oe_n = 1'b1; we_n = 1'b1; ce1_n = 1'b1; ce2 = 1'b0;
    byte_n = 1'b1; ble_n = 1'b1; bhe_n = 1'b1; addr = '0;
  endtask

  task automatic do_reset();
    set_idle();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic write_like();
    oe_n = 1'b1; we_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1;
  endtask

  task automatic enter_simul();
    set_idle();
    tick(2);
    oe_n = 1'b0; we_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1;
    tick(1);
  endtask

  task automatic send_cmd(input logic [1:0] m);
    addr = {KEY, 6'b0, m, 1'b0};
    tick(1);
    addr[0] = 1'b1;
    tick(1);
  endtask

  function automatic logic [7:0] cont_exp(input logic [15:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = a[i] ^ a[15-i];
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    set_idle();
    tick(2);
    chk("R1 test_mode in reset", test_mode, 0);
    chk("R1 data_out in reset", data_out, 0);
    chk("R1 data_oe in reset", data_oe, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 test_mode after reset", test_mode, 0);
  endtask

  task automatic t_timed_entry();
    do_reset();
    byte_n = 1'b0;
    write_like();
    tick(HOLD);
    chk("R2 no entry one sample short", test_mode, 0);
    tick(1);
    chk("R2 entry after full window", test_mode, 1);
    tick(4);
    chk("R5 held write pattern does not exit", test_mode, 1);
    we_n = 1'b1;
    tick(1);
    chk("R5 still in mode after release", test_mode, 1);
    we_n = 1'b0;
    tick(1);
    chk("R5 write exits", test_mode, 0);
  endtask

  task automatic t_timed_restart();
    do_reset();
    byte_n = 1'b0;
    write_like();
    tick(10);
    we_n = 1'b1;
    tick(1);
    we_n = 1'b0;
    tick(HOLD);
    chk("R2 broken window restarts count", test_mode, 0);
    tick(1);
    chk("R2 entry after fresh full window", test_mode, 1);
  endtask

  task automatic t_qualifier();
    do_reset();
    byte_n = 1'b1; ble_n = 1'b0; bhe_n = 1'b1;
    write_like();
    tick(2*HOLD);
    chk("R3 single byte enable no entry", test_mode, 0);
    do_reset();
    byte_n = 1'b1; ble_n = 1'b0; bhe_n = 1'b0;
    write_like();
    tick(HOLD+1);
    chk("R3 both byte enables enter", test_mode, 1);
  endtask

  task automatic t_simul_entry();
    do_reset();
    enter_simul();
    chk("R4 simultaneous activation enters", test_mode, 1);
    tick(1);
    chk("R12 data_oe with oe_n low in mode", data_oe, 1);
    oe_n = 1'b1; we_n = 1'b1;
    tick(2);
    chk("R12 data_oe off with oe_n high", data_oe, 0);
    do_reset();
    tick(1);
    oe_n = 1'b0;
    tick(1);
    we_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1;
    tick(3);
    chk("R4 staggered activation no entry", test_mode, 0);
  endtask

  task automatic t_continuity();
    logic [15:0] pats [6];
    do_reset();
    addr = 19'h0_00FF;
    tick(2);
    chk("R12 data_out zero outside mode", data_out, 0);
    enter_simul();
    pats[0] = 16'h0001; pats[1] = 16'h8000; pats[2] = 16'h8001;
    pats[3] = 16'h00FF; pats[4] = 16'h3C5A; pats[5] = 16'hFFFF;
    for (int p = 0; p < 6; p++) begin
      addr = {3'b000, pats[p]};
      tick(1);
      chk("R7 continuity response", data_out, cont_exp(pats[p]));
    end
  endtask

  task automatic t_cmd_exit();
    do_reset();
    enter_simul();
    addr = 19'h1;
    tick(1);
    addr = {XPAT, 1'b1};
    tick(3);
    chk("R6 level pattern does not exit", test_mode, 1);
    addr = {XPAT, 1'b0};
    tick(1);
    chk("R6 still in mode before edge", test_mode, 1);
    addr[0] = 1'b1;
    tick(1);
    chk("R6 pattern with rising bit exits", test_mode, 0);
  endtask

  task automatic t_identifier();
    do_reset();
    enter_simul();
    send_cmd(2'b01);
    for (int s = 0; s < 4; s++) begin
      addr = {14'b0, 2'(s), 3'b000};
      tick(1);
      chk("R9 identifier byte", data_out, TB_ID[8*(3-s) +: 8]);
    end
    send_cmd(2'b11);
    for (int k = 0; k < 32; k += 5) begin
      addr = {11'b0, 5'(k), 3'b000};
      tick(1);
      chk("R10 identifier bit", data_out, {7'b0, TB_ID[k]});
    end
    send_cmd(2'b00);
    addr = 19'h0_0001;
    tick(1);
    chk("R8 command back to continuity", data_out, 8'h01);
  endtask

  task automatic read_cnt(input logic [1:0] s, input logic [7:0] exp, input string tag);
    addr = {14'b0, s, 3'b000};
    tick(1);
    chk(tag, data_out, exp);
  endtask

  task automatic t_counters();
    do_reset();
    enter_simul();
    send_cmd(2'b10);
    addr = '0;
    for (int i = 0; i < 3; i++) begin we_n = 1'b1; tick(1); we_n = 1'b0; tick(1); end
    we_n = 1'b1;
    tick(1);
    for (int i = 0; i < 5; i++) begin oe_n = 1'b1; tick(1); oe_n = 1'b0; tick(1); end
    for (int i = 0; i < 2; i++) begin ce1_n = 1'b1; tick(1); ce1_n = 1'b0; tick(1); end
    read_cnt(2'd0, 8'd5, "R11 OE counter");
    read_cnt(2'd1, 8'd3, "R11 WE counter");
    read_cnt(2'd2, 8'd2, "R11 CE1 counter");
    read_cnt(2'd3, 8'd0, "R11 unused select reads zero");
    for (int i = 0; i < 260; i++) begin oe_n = 1'b1; tick(1); oe_n = 1'b0; tick(1); end
    read_cnt(2'd0, 8'd255, "R11 OE counter saturates");
    addr = {XPAT, 1'b0};
    tick(1);
    addr[0] = 1'b1;
    tick(1);
    chk("R6 exit before re-entry", test_mode, 0);
    enter_simul();
    chk("R4 re-entry", test_mode, 1);
    send_cmd(2'b10);
    read_cnt(2'd0, 8'd0, "R11 counters cleared on entry");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_idle();
    t_reset();
    t_timed_entry();
    t_timed_restart();
    t_qualifier();
    t_simul_entry();
    t_continuity();
    t_cmd_exit();
    t_identifier();
    t_counters();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule